// File: doc/BRIEF.md
# Even-Parity Serial Byte Receiver

This block turns an idle-high asynchronous serial line back into bytes. A frame opens with a low start bit, carries the data bits with the least significant bit first, follows them with one parity bit chosen so that the total number of ones is even, and closes with a high stop bit. Every bit lasts `BAUD_DIV` clock cycles. The block uses the same divider setting as its matching transmitter, so the two can be wired back to back in a loopback.

The serial input first passes through a two-flop synchroniser. A falling edge on the synchronised line while idle opens a frame. The start bit is sampled again half a bit period later, and a high level at that point is treated as noise and dropped. After that, one sample is taken every `BAUD_DIV` cycles, close to the middle of each bit. Data bits are shifted into a holding register. When the stop bit samples high, that register is copied to the byte output, a one-cycle valid strobe is raised, and the parity result appears on the same cycle.

Top module: `uart_even_rx`

## Requirements
- R1: While reset is applied and on the first cycle after it, `rx_data` reads 0x00 and `rx_valid` and `rx_perr` read 0.
- R2: For every 8-bit value sent as start(0), bits 0 to 7 least significant first, parity, stop(1), each bit held `BAUD_DIV` cycles, `rx_data` presents exactly that value on the cycle `rx_valid` is high.
- R3: `rx_data` changes only on a cycle where `rx_valid` is high. At all other times it holds its last accepted value.
- R4: Each accepted frame raises `rx_valid` for exactly one clock cycle. It is never high on two consecutive cycles.
- R5: `rx_perr` is 1 on the valid cycle when the eight data bits plus the parity bit hold an odd number of ones. It is 0 when that number is even.
- R6: `rx_perr` is never 1 unless `rx_valid` is 1 on the same cycle.
- R7: A frame whose stop bit samples low produces no `rx_valid` pulse and leaves `rx_data` unchanged. A correct frame that follows it is received normally.
- R8: A low pulse on an idle line that is shorter than half a bit period produces no `rx_valid` pulse and leaves `rx_data` unchanged. A correct frame that follows it is received normally.
- R9: Frames sent back to back, with the next start bit directly after the previous stop bit, are each accepted with their own values.
- R10: An accepted frame's stop bit was sampled high: the synchronised line was 1 on the cycle before `rx_valid` rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_line | input | 1 | Serial input, idle high |
| rx_data | output | 8 | Last accepted byte |
| rx_valid | output | 1 | One-cycle strobe marking a new byte |
| rx_perr | output | 1 | Parity mismatch flag, valid with `rx_valid` |

## Verification
The hardest conditions to reach are the ones where the receiver must stay silent: a low stop bit, and a start glitch that is gone by mid-bit. In both, the line looks like a normal frame opening. The bench drives each of these deliberately and then follows it at once with a correct frame, which shows that no pulse appeared and that the state machine recovered. Parity errors come from a second full sweep of all 256 values with the parity bit inverted, and the back-to-back case is made by leaving no idle time between two stop and start bits.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_START  = 3'd1,
        ST_DATA   = 3'd2,
        ST_PARITY = 3'd3,
        ST_STOP   = 3'd4
    } rx_state_e;
endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic line_o,
    output logic fall_o
);
    localparam int PW = STAGES + 1;

    logic [PW-1:0] pipe_d, pipe_q;

    always_comb begin
        pipe_d = {pipe_q[PW-2:0], line_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '1;
        else        pipe_q <= pipe_d;
    end

    // synchronised level and a falling edge seen one flop later
    assign line_o = pipe_q[STAGES-1];
    assign fall_o = pipe_q[STAGES] & ~pipe_q[STAGES-1];
endmodule

// File: rtl/uart_rx_bit_timer.sv
module uart_rx_bit_timer #(
    parameter int BAUD_DIV = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart_i,
    input  logic half_i,
    output logic tick_o
);
    localparam int CW   = $clog2(BAUD_DIV + 1);
    localparam int HALF = (BAUD_DIV / 2 < 1) ? 1 : BAUD_DIV / 2;

    logic [CW-1:0] cnt_d, cnt_q;
    logic [CW-1:0] limit;

    always_comb begin
        limit  = half_i ? CW'(HALF - 1) : CW'(BAUD_DIV - 1);
        tick_o = !restart_i && (cnt_q == limit);
        if (restart_i || tick_o) cnt_d = '0;
        else                     cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/uart_even_rx.sv
module uart_even_rx #(
    parameter int BAUD_DIV = 8,
    parameter int DATA_W   = 8,
    parameter int SYNC_N   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_line,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_valid,
    output logic              rx_perr
);
    import uart_rx_pkg::*;

    localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;

    typedef struct packed {
        rx_state_e         st;
        logic [DATA_W-1:0] shift;
        logic [IDX_W-1:0]  idx;
        logic              par;
        logic [DATA_W-1:0] dout;
        logic              valid;
        logic              perr;
    } rx_regs_t;

    rx_regs_t  regs_d, regs_q;
    logic      line_s, fall_s, tick, restart, half_sel;
    logic [2:0] state_w;

    uart_rx_sync #(.STAGES(SYNC_N)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .line_i (rx_line),
        .line_o (line_s),
        .fall_o (fall_s)
    );

    uart_rx_bit_timer #(.BAUD_DIV(BAUD_DIV)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart_i (restart),
        .half_i    (half_sel),
        .tick_o    (tick)
    );

    always_comb begin
        regs_d       = regs_q;
        regs_d.valid = 1'b0;
        regs_d.perr  = 1'b0;
        restart      = 1'b0;
        half_sel     = (regs_q.st == ST_START);
        unique case (regs_q.st)
            ST_IDLE: begin
                if (fall_s) begin
                    restart   = 1'b1;
                    regs_d.st = ST_START;
                end
            end
            ST_START: begin
                if (tick) begin
                    regs_d.idx = '0;
                    regs_d.st  = line_s ? ST_IDLE : ST_DATA;
                end
            end
            ST_DATA: begin
                if (tick) begin
                    regs_d.shift = {line_s, regs_q.shift[DATA_W-1:1]};
                    if (regs_q.idx == IDX_W'(DATA_W - 1)) regs_d.st = ST_PARITY;
                    else regs_d.idx = regs_q.idx + 1'b1;
                end
            end
            ST_PARITY: begin
                if (tick) begin
                    regs_d.par = line_s;
                    regs_d.st  = ST_STOP;
                end
            end
            ST_STOP: begin
                if (tick) begin
                    regs_d.st = ST_IDLE;
                    if (line_s) begin
                        regs_d.dout  = regs_q.shift;
                        regs_d.valid = 1'b1;
                        regs_d.perr  = ^{regs_q.shift, regs_q.par};
                    end
                end
            end
            default: regs_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '{st: ST_IDLE, shift: '0, idx: '0, par: 1'b0,
                        dout: '0, valid: 1'b0, perr: 1'b0};
        end else begin
            regs_q <= regs_d;
        end
    end

    assign state_w  = regs_q.st;
    assign rx_data  = regs_q.dout;
    assign rx_valid = regs_q.valid;
    assign rx_perr  = regs_q.perr;
endmodule

// File: rtl/uart_rx_checker.sv
module uart_rx_checker #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              line_sync,
    input logic [2:0]        state,
    input logic [DATA_W-1:0] rx_data,
    input logic              rx_valid,
    input logic              rx_perr
);
    AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid); // R4

    AST_PERR_ONLY_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        rx_perr |-> rx_valid); // R6

    AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_valid |-> $stable(rx_data)); // R3

    AST_STOP_SAMPLED_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_valid) |-> $past(line_sync)); // R10

    AST_STATE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        state <= 3'd4); // R2
endmodule

bind uart_even_rx uart_rx_checker #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .line_sync (line_s),
    .state     (state_w),
    .rx_data   (rx_data),
    .rx_valid  (rx_valid),
    .rx_perr   (rx_perr)
);

// File: tb/sim_uart_even_rx.sv
module sim_uart_even_rx;
    localparam int BAUD = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_line = 1'b1;
    logic [7:0] rx_data;
    logic       rx_valid;
    logic       rx_perr;

    int n_chk = 0;
    int n_fail = 0;
    int vcnt = 0;
    logic [7:0] cap_d [0:7];
    logic       cap_p [0:7];
    bit prev_v = 0;
    bit dbl = 0;
    bit lone_perr = 0;
    bit done = 0;

    always #4 clk = ~clk;

    uart_even_rx #(.BAUD_DIV(BAUD)) u0 (
        .clk(clk), .rst_n(rst_n), .rx_line(rx_line),
        .rx_data(rx_data), .rx_valid(rx_valid), .rx_perr(rx_perr)
    );

    always @(negedge clk) begin
        if (rst_n) begin
            if (rx_valid) begin
                cap_d[vcnt % 8] = rx_data;
                cap_p[vcnt % 8] = rx_perr;
                vcnt++;
                if (prev_v) dbl = 1;
            end
            if (rx_perr && !rx_valid) lone_perr = 1;
            prev_v = rx_valid;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic drive_bit(input logic v);
        rx_line = v;
        repeat (BAUD) @(negedge clk);
    endtask

    task automatic send(input logic [7:0] b, input logic bad, input logic stop_lvl, input int gap);
        drive_bit(1'b0);
        for (int i = 0; i < 8; i++) drive_bit(b[i]);
        drive_bit((^b) ^ bad);
        drive_bit(stop_lvl);
        for (int g = 0; g < gap; g++) drive_bit(1'b1);
    endtask

    task automatic good_frame(input logic [7:0] b, input logic bad, input string tag);
        int v0;
        v0 = vcnt;
        send(b, bad, 1'b1, 1);
        chk(vcnt == v0 + 1, {tag, " pulse count"}, vcnt - v0, 1);
        chk(cap_d[v0 % 8] == b, {tag, " data"}, cap_d[v0 % 8], b);
        chk(cap_p[v0 % 8] == bad, {tag, " parity flag"}, cap_p[v0 % 8], bad);
    endtask

    initial begin
        int v0;
        logic [7:0] d0;
        repeat (3) @(negedge clk);
        // R1: reset values
        chk(rx_data == 8'h00, "R1 data in reset", rx_data, 0);
        chk(!rx_valid && !rx_perr, "R1 flags in reset", {rx_valid, rx_perr}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(rx_data == 8'h00 && !rx_valid && !rx_perr, "R1 after release",
            {rx_valid, rx_perr, rx_data}, 0);
        repeat (4) @(negedge clk);

        // R2 R5: full sweep, correct parity
        for (int b = 0; b < 256; b++) good_frame(8'(b), 1'b0, "R2");
        // R5: full sweep, inverted parity
        for (int b = 0; b < 256; b++) good_frame(8'(b), 1'b1, "R5");

        // R7: stop bit low is dropped
        v0 = vcnt; d0 = rx_data;
        send(8'h3C, 1'b0, 1'b0, 2);
        chk(vcnt == v0, "R7 no pulse on bad stop", vcnt - v0, 0);
        chk(rx_data == d0, "R7 data held", rx_data, d0);
        good_frame(8'hC3, 1'b0, "R7 recovery");

        // R8: short start glitch
        v0 = vcnt; d0 = rx_data;
        rx_line = 1'b0;
        repeat (2) @(negedge clk);
        rx_line = 1'b1;
        repeat (3 * BAUD) @(negedge clk);
        chk(vcnt == v0, "R8 no pulse on glitch", vcnt - v0, 0);
        chk(rx_data == d0, "R8 data held", rx_data, d0);
        good_frame(8'h81, 1'b0, "R8 recovery");

        // R9: back-to-back frames
        v0 = vcnt;
        send(8'hA5, 1'b0, 1'b1, 0);
        send(8'h5A, 1'b0, 1'b1, 0);
        send(8'h0F, 1'b1, 1'b1, 2);
        chk(vcnt == v0 + 3, "R9 three pulses", vcnt - v0, 3);
        chk(cap_d[v0 % 8] == 8'hA5, "R9 first", cap_d[v0 % 8], 8'hA5);
        chk(cap_d[(v0 + 1) % 8] == 8'h5A, "R9 second", cap_d[(v0 + 1) % 8], 8'h5A);
        chk(cap_d[(v0 + 2) % 8] == 8'h0F && cap_p[(v0 + 2) % 8],
            "R9 third with parity error", cap_d[(v0 + 2) % 8], 8'h0F);

        // R4 R6 R3: strobe shape seen over the whole run
        chk(!dbl, "R4 valid never two cycles", dbl, 0);
        chk(!lone_perr, "R6 perr only with valid", lone_perr, 0);
        chk(!rx_valid, "R3 idle after run", rx_valid, 0);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule